// File: doc/BRIEF.md
# Press-Gated Running Sum

This block keeps a running sum of a 24-bit word read from a bank of slow, unclocked switches. It does not add on every clock. The total advances only once for each press of a pushbutton, however long the button stays down. The sum is held in an internal register and fed back to its own adder, so the previous total is never a module input.

The switch bank is three lanes of eight bits. Each bit crosses into the clock domain through its own flip-flop synchronizer. The button uses the same kind of synchronizer. After that, a conditioner accepts the button level only once it has stayed high for a set number of consecutive cycles, which rejects contact bounce. A one-cycle pulse marks the conditioned level going from 0 to 1, and that pulse is the load enable of the total. On overflow the total wraps, and nothing else reports it.

Top module: `tally_accum`

## Requirements
- R1: While reset is high and on the first cycle after it, `total_o` is zero. Reset also clears every synchronizer, conditioner and edge flip-flop.
- R2: On a press the total becomes its previous value plus the synchronized switch word. Switch bit i (lane i/8, bit i%8) adds weight 2^i.
- R3: On any cycle without a press pulse, `total_o` holds its value. This holds even while the switches change or the button stays high.
- R4: Each switch bit passes through SYNC_STAGES (default 2) flip-flops before it reaches the adder. A word that is steady on the pins when the button goes high is the word that gets added.
- R5: The button counts as pressed only after its synchronized level has been 1 for HOLD_CYCLES consecutive cycles. A high pulse shorter than that adds nothing.
- R6: When the synchronized button is 0, the conditioned level is 0 on the next cycle and the hold count starts again.
- R7: The press pulse lasts exactly one cycle. A button held for hundreds of cycles adds exactly once.
- R8: The total is 24 bits wide and wraps modulo 2^24.
- R9: With the button low, releasing reset produces no press, and the total stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sw_i | input | 24 | Unsynchronized switch word, three 8-bit lanes |
| btn_i | input | 1 | Unsynchronized pushbutton, active high |
| total_o | output | 24 | Running total |

## Verification
Every cycle, the assertions check that the total moves only on a press pulse and then by exactly the synchronized word. They also check that the pulse never lasts two cycles and that the conditioned level falls one cycle after the synchronized button goes low. Some behaviours only the bench scenarios can show, because they depend on a whole sequence of stimulus: bounce rejection for short pulses, a single add across a long hold, wrap across 2^24, and the quiet release from reset.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int DEF_SYNC_STAGES = 2;

  // Width needed to count from 0 up to and including n.
  function automatic int count_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int WIDTH  = 8,
  parameter int STAGES = tally_pkg::DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int HOLD_CYCLES = 16,
  parameter int STAGES      = tally_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic held
);
  localparam int CW = tally_pkg::count_width(HOLD_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic          btn_s;
  logic [CW-1:0] cnt_q;

  sync_chain #(.WIDTH(1), .STAGES(STAGES)) u_bsync (
    .clk(clk), .rst(rst), .d(btn_raw), .q(btn_s)
  );

  always_ff @(posedge clk) begin
    if (rst || !btn_s)      cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign held = (cnt_q == LIMIT);

  // R6: a low synchronized button clears the conditioned level next cycle
  p_cond_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !btn_s |=> !held);
  // R5: the conditioned level only rises after the synchronized button was high
  p_cond_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> $past(btn_s));
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign pulse = level & ~prev_q;

  // R7: a press pulse is never followed by another pulse on the next cycle
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/tally_accum.sv
module tally_accum #(
  parameter int LANES       = 3,
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = tally_pkg::DEF_SYNC_STAGES,
  parameter int HOLD_CYCLES = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*LANE_W-1:0]   sw_i,
  input  logic                      btn_i,
  output logic [LANES*LANE_W-1:0]   total_o
);
  localparam int IN_W = LANES * LANE_W;

  function automatic logic [IN_W-1:0] wrap_add(input logic [IN_W-1:0] a,
                                               input logic [IN_W-1:0] b);
    return a + b;
  endfunction

  logic [IN_W-1:0] sw_sync;
  logic            btn_level;
  logic            press_pulse;
  logic [IN_W-1:0] total_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sync_chain #(.WIDTH(LANE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst),
      .d(sw_i[g*LANE_W +: LANE_W]),
      .q(sw_sync[g*LANE_W +: LANE_W])
    );
  end

  btn_conditioner #(.HOLD_CYCLES(HOLD_CYCLES), .STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .btn_raw(btn_i), .held(btn_level)
  );

  rise_detect u_edge (
    .clk(clk), .rst(rst), .level(btn_level), .pulse(press_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)              total_q <= '0;
    else if (press_pulse) total_q <= wrap_add(total_q, sw_sync);
  end

  assign total_o = total_q;

  // R1: the cycle after reset the total reads zero
  p_reset_zero_r1: assert property (@(posedge clk)
    $past(rst) |-> total_o == '0);
  // R2: a press adds the synchronized word, truncated to the total width (R8)
  p_press_adds_r2: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> (total_o - $past(total_o)) == $past(sw_sync));
  // R3: without a press the total does not move
  p_total_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !press_pulse |=> $stable(total_o));
endmodule

// File: tb/sim_tally_accum.sv
module sim_tally_accum;
  localparam int HOLD = 16;
  localparam int NV   = 8;
  localparam logic [23:0] VEC_SW [NV] = '{
    24'h000001, 24'h0000FF, 24'h00FF00, 24'hFF0000,
    24'h123456, 24'h000000, 24'hFFFFFF, 24'h800000
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] sw;
  logic        btn;
  logic [23:0] total;
  logic [23:0] expv;
  int          n_cmp  = 0;
  int          n_bad  = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  tally_accum #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst(rst), .sw_i(sw), .btn_i(btn), .total_o(total)
  );

  task automatic check(input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: total=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int len);
    btn = 1'b1; cyc(len);
    btn = 1'b0; cyc(HOLD / 2);
  endtask

  initial begin
    rst = 1'b1; sw = 24'h0; btn = 1'b0;
    cyc(3);
    check("R1 during reset", total, 24'h0);
    rst = 1'b0; cyc(1);
    check("R1 after release", total, 24'h0);
    cyc(40);
    check("R9 quiet release", total, 24'h0);

    // R2, R4, R8: vector walk with running expected sum
    expv = 24'h0;
    for (int i = 0; i < NV; i++) begin
      sw = VEC_SW[i];
      press(HOLD + 8);
      expv = expv + VEC_SW[i];
      check("R2/R4/R8 vector", total, expv);
    end

    // R5: bounce shorter than the hold time adds nothing
    sw = 24'h000010;
    press(HOLD / 2);
    check("R5 short pulse ignored", total, expv);
    press(HOLD - 3);
    check("R5 near-threshold pulse ignored", total, expv);

    // R7: long hold adds once; R3: switches change while held
    sw = 24'h000100;
    btn = 1'b1; cyc(HOLD + 8);
    expv = expv + 24'h000100;
    check("R7 first add during hold", total, expv);
    sw = 24'h0F0F0F; cyc(300);
    check("R3/R7 no re-add while held", total, expv);
    btn = 1'b0; cyc(HOLD);
    check("R3 release adds nothing", total, expv);

    // R6: a gap of one low cycle restarts the hold count
    sw = 24'h000002;
    btn = 1'b1; cyc(HOLD - 4);
    btn = 1'b0; cyc(1);
    btn = 1'b1; cyc(HOLD - 4);
    btn = 1'b0; cyc(HOLD);
    check("R6 interrupted hold ignored", total, expv);

    // R8: wrap exactly to zero
    sw = 24'h000000 - expv;
    press(HOLD + 8);
    check("R8 wrap to zero", total, 24'h0);

    // R1: reset mid-run clears the total
    sw = 24'h00ABCD;
    press(HOLD + 8);
    check("R2 add after wrap", total, 24'h00ABCD);
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
    check("R1 mid-run reset", total, 24'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule